// File: doc/BRIEF.md
# Scan Chain Device Enumerator

This block masters an external boundary-scan chain of unknown length. It drives the test clock, mode select and serial data lines, and it samples the chain's serial return. After a one-cycle start request it does three things in order. It forces every device's test access port into its reset state. It loads an all-ones instruction into every device so that each one presents only its one-bit bypass path. It then sends a lone marker bit through the chain and counts the test clock cycles the marker needs to reach the return line.

That count is the number of devices. The master then resets the chain a second time. After this reset each device presents its 32-bit identification word by default, and the master reads all of these words in one data shift. Each word goes out on a word port with a one-cycle strobe. The device nearest the return line comes first, and each word is assembled least significant bit first.

The scan clock is derived from the system clock through a divider that the host sets. When everything is finished the chain is parked in Run-Test/Idle and a one-cycle completion pulse is raised.

Top module: `jtag_enum_master`

## Requirements
- R1: After an accepted start, mode select is high during the first five scan clock rising edges and low on the sixth. This brings the chain to Test-Logic-Reset from any state.
- R2: The scan clock period is 2*(div+1) system clock cycles. The scan clock rests low whenever the block is idle, including after reset. `div` must be held stable during a run.
- R3: Mode select and serial out change only on a system clock edge where the scan clock falls. The return line is sampled on the edge where the scan clock rises.
- R4: The instruction fill shifts IR_MAX ones with mode select high on the last bit. Every device therefore ends the fill holding an all-ones instruction.
- R5: After zeros flush the bypass path, a single 1 is sent. `dev_count` equals the number of scan clock rises between sending the 1 and seeing it on the return line, which is the number of devices. `dev_count` never exceeds MAX_DEV.
- R6: If the marker has not returned after MAX_DEV further rises, `err` is 1 and `dev_count` is 0. No identification word is produced in that case.
- R7: For a count of N, exactly N words are produced, each with a one-cycle `id_valid` pulse. The device nearest the return line comes first, and the first bit received lands in bit 0.
- R8: At the end of every run the chain is in Run-Test/Idle, the scan clock is low, and `done` is high for exactly one system clock.
- R9: A chain of zero length, with the return line wired straight to serial out, gives `dev_count` 0, `err` 0 and no words.
- R10: A start request that arrives while a run is in progress is ignored and leaves the results of that run unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to enumerate the chain |
| div | input | DIV_W | Half-period of the scan clock minus one, in system clocks |
| tdo | input | 1 | Serial return from the last device in the chain |
| tck | output | 1 | Scan clock |
| tms | output | 1 | Mode select to every device |
| tdi | output | 1 | Serial data into the first device |
| dev_count | output | clog2(MAX_DEV+1) | Measured number of devices |
| id_word | output | ID_W | Captured identification word |
| id_valid | output | 1 | One-cycle strobe for `id_word` |
| err | output | 1 | Marker never returned in the last run |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with DIV_W=4, IR_MAX=24 and MAX_DEV=4, against a behavioural chain of up to four devices whose instruction lengths run from 4 to 7 bits, 22 in total. With these values the full four-device chain lands exactly on the MAX_DEV bound for the marker search, and a stuck-low return line reaches the error path after only a few cycles. A div of 0 exercises the fastest two-cycle scan clock. The short maximum count also keeps every run, including the 128-bit identification shift, well inside the cycle budget.

// File: rtl/jem_pkg.sv
package jem_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_RST1,
    PH_TO_SIR,
    PH_SIR,
    PH_TO_SDR1,
    PH_FLUSH,
    PH_MEAS,
    PH_RST2,
    PH_TO_SDR2,
    PH_IDSH,
    PH_EXIT,
    PH_STOP
  } phase_t;

  // Mode-select walks, bit k is the value for walk cycle k.
  // Test-Logic-Reset -> Idle -> Sel-DR -> Sel-IR -> Capture-IR -> Shift-IR
  localparam logic [7:0] WALK_TO_SIR  = 8'b0000_0110;
  // Exit1-IR -> Update-IR -> Sel-DR -> Capture-DR -> Shift-DR
  localparam logic [7:0] WALK_IR_TO_DR = 8'b0000_0011;
  // Test-Logic-Reset -> Idle -> Sel-DR -> Capture-DR -> Shift-DR
  localparam logic [7:0] WALK_RST_TO_DR = 8'b0000_0010;
  // Shift-DR -> Exit1-DR -> Update-DR -> Idle
  localparam logic [7:0] WALK_PARK    = 8'b0000_0011;

  localparam int unsigned RESET_HOLD = 5;

endpackage

// File: rtl/jem_tck_gen.sv
module jem_tck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tck,
  output logic             rise_en,
  output logic             fall_en
);

  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap    = run && (cnt == div);
  assign rise_en = wrap && !tck;
  assign fall_en = wrap && tck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      tck <= ~tck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/jem_id_cap.sv
module jem_id_cap #(
  parameter int ID_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cap_en,
  input  logic            tdo,
  output logic [ID_W-1:0] id_word,
  output logic            id_valid
);

  localparam int BW = (ID_W > 1) ? $clog2(ID_W) : 1;

  logic [ID_W-1:0] sh;
  logic [BW-1:0]   bcnt;
  logic [ID_W-1:0] sh_next;

  assign sh_next = {tdo, sh[ID_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      bcnt     <= '0;
      id_word  <= '0;
      id_valid <= 1'b0;
    end else begin
      id_valid <= 1'b0;
      if (cap_en) begin
        sh <= sh_next;
        if (bcnt == BW'(ID_W - 1)) begin
          bcnt     <= '0;
          id_word  <= sh_next;
          id_valid <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

  // R7
  id_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    id_valid |=> !id_valid);

endmodule

// File: rtl/jem_seq.sv
module jem_seq
  import jem_pkg::*;
#(
  parameter int IR_MAX  = 32,
  parameter int MAX_DEV = 8,
  parameter int ID_W    = 32,
  parameter int DEV_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             rise_en,
  input  logic             fall_en,
  input  logic             tdo,
  output logic             run,
  output logic             tms,
  output logic             tdi,
  output logic             cap_en,
  output logic [DEV_W-1:0] dev_count,
  output logic             err,
  output logic             done
);

  localparam int SPAN  = ((ID_W * MAX_DEV > IR_MAX) ? ID_W * MAX_DEV : IR_MAX) + 1;
  localparam int CNT_W = $clog2(SPAN + 1);
  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t C_RST_LAST  = cnt_t'(RESET_HOLD - 1);
  localparam cnt_t C_WALK5     = cnt_t'(4);
  localparam cnt_t C_WALK4     = cnt_t'(3);
  localparam cnt_t C_PARK_LAST = cnt_t'(2);
  localparam cnt_t C_IR_LAST   = cnt_t'(IR_MAX - 1);
  localparam cnt_t C_FL_LAST   = cnt_t'(MAX_DEV - 1);
  localparam cnt_t C_MEAS_MAX  = cnt_t'(MAX_DEV);

  phase_t     ph, ph_n;
  cnt_t       cnt, cnt_n;
  cnt_t       id_last;
  logic       nxt_tms, nxt_tdi;
  logic [DEV_W-1:0] dev_q;

  assign id_last   = cnt_t'(dev_q) * cnt_t'(ID_W) - cnt_t'(1);
  assign dev_count = dev_q;
  assign cap_en    = rise_en && (ph == PH_IDSH);

  function automatic logic tms_of(phase_t p, cnt_t c);
    case (p)
      PH_RST1, PH_RST2: tms_of = 1'b1;
      PH_TO_SIR:        tms_of = WALK_TO_SIR[c[2:0]];
      PH_SIR:           tms_of = (c == C_IR_LAST);
      PH_TO_SDR1:       tms_of = WALK_IR_TO_DR[c[2:0]];
      PH_TO_SDR2:       tms_of = WALK_RST_TO_DR[c[2:0]];
      PH_EXIT:          tms_of = WALK_PARK[c[2:0]];
      default:          tms_of = 1'b0;
    endcase
  endfunction

  function automatic logic tdi_of(phase_t p, cnt_t c);
    case (p)
      PH_SIR:  tdi_of = 1'b1;
      PH_MEAS: tdi_of = (c == '0);
      default: tdi_of = 1'b0;
    endcase
  endfunction

  // Phase walk, evaluated for the scan cycle that ends at this rising edge.
  always_comb begin
    ph_n  = ph;
    cnt_n = cnt + 1'b1;
    case (ph)
      PH_RST1:    if (cnt == C_RST_LAST) begin ph_n = PH_TO_SIR;  cnt_n = '0; end
      PH_TO_SIR:  if (cnt == C_WALK5)    begin ph_n = PH_SIR;     cnt_n = '0; end
      PH_SIR:     if (cnt == C_IR_LAST)  begin ph_n = PH_TO_SDR1; cnt_n = '0; end
      PH_TO_SDR1: if (cnt == C_WALK4)    begin ph_n = PH_FLUSH;   cnt_n = '0; end
      PH_FLUSH:   if (cnt == C_FL_LAST)  begin ph_n = PH_MEAS;    cnt_n = '0; end
      PH_MEAS: begin
        if (tdo) begin
          ph_n  = (cnt == '0) ? PH_EXIT : PH_RST2;
          cnt_n = '0;
        end else if (cnt == C_MEAS_MAX) begin
          ph_n  = PH_EXIT;
          cnt_n = '0;
        end
      end
      PH_RST2:    if (cnt == C_RST_LAST)  begin ph_n = PH_TO_SDR2; cnt_n = '0; end
      PH_TO_SDR2: if (cnt == C_WALK4)     begin ph_n = PH_IDSH;    cnt_n = '0; end
      PH_IDSH:    if (cnt == id_last)     begin ph_n = PH_EXIT;    cnt_n = '0; end
      PH_EXIT:    if (cnt == C_PARK_LAST) begin ph_n = PH_STOP;    cnt_n = '0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      run     <= 1'b0;
      tms     <= 1'b1;
      tdi     <= 1'b0;
      nxt_tms <= 1'b1;
      nxt_tdi <= 1'b0;
      dev_q   <= '0;
      err     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (ph == PH_IDLE) begin
        if (start) begin
          ph    <= PH_RST1;
          cnt   <= '0;
          run   <= 1'b1;
          tms   <= 1'b1;
          tdi   <= 1'b0;
          dev_q <= '0;
          err   <= 1'b0;
        end
      end else if (ph == PH_STOP) begin
        if (fall_en) begin
          tms  <= nxt_tms;
          tdi  <= nxt_tdi;
          run  <= 1'b0;
          done <= 1'b1;
          ph   <= PH_IDLE;
        end
      end else begin
        if (rise_en) begin
          ph      <= ph_n;
          cnt     <= cnt_n;
          nxt_tms <= tms_of(ph_n, cnt_n);
          nxt_tdi <= tdi_of(ph_n, cnt_n);
          if (ph == PH_MEAS) begin
            if (tdo)                     dev_q <= cnt[DEV_W-1:0];
            else if (cnt == C_MEAS_MAX)  err   <= 1'b1;
          end
        end
        if (fall_en) begin
          tms <= nxt_tms;
          tdi <= nxt_tdi;
        end
      end
    end
  end

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (dev_count == '0));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(dev_count) <= MAX_DEV));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/jtag_enum_master.sv
module jtag_enum_master #(
  parameter int DIV_W   = 8,
  parameter int IR_MAX  = 32,
  parameter int MAX_DEV = 8,
  parameter int ID_W    = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [DIV_W-1:0]               div,
  input  logic                           tdo,
  output logic                           tck,
  output logic                           tms,
  output logic                           tdi,
  output logic [$clog2(MAX_DEV+1)-1:0]   dev_count,
  output logic [ID_W-1:0]                id_word,
  output logic                           id_valid,
  output logic                           err,
  output logic                           done
);

  localparam int DEV_W = $clog2(MAX_DEV + 1);

  logic run, rise_en, fall_en, cap_en;

  jem_tck_gen #(.DIV_W(DIV_W)) u_tck (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .div     (div),
    .tck     (tck),
    .rise_en (rise_en),
    .fall_en (fall_en)
  );

  jem_seq #(
    .IR_MAX  (IR_MAX),
    .MAX_DEV (MAX_DEV),
    .ID_W    (ID_W),
    .DEV_W   (DEV_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .tdo       (tdo),
    .run       (run),
    .tms       (tms),
    .tdi       (tdi),
    .cap_en    (cap_en),
    .dev_count (dev_count),
    .err       (err),
    .done      (done)
  );

  jem_id_cap #(.ID_W(ID_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .tdo      (tdo),
    .id_word  (id_word),
    .id_valid (id_valid)
  );

  // R3
  tms_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$stable(tms)) |-> ($past(tck) && !tck));

  // R3
  tdi_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && !$stable(tdi)) |-> ($past(tck) && !tck));

  // R8
  done_tck_low_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !tck);

endmodule

// File: tb/jtag_enum_master_bench.sv
module jtag_enum_master_bench;
  localparam int DIV_W = 4, IR_MAX = 24, MAX_DEV = 4, ID_W = 32;
  localparam int DEV_W = $clog2(MAX_DEV + 1);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [DIV_W-1:0] div = 4'd1;
  logic tdo;
  wire  tck, tms, tdi;
  logic [DEV_W-1:0] dev_count;
  logic [ID_W-1:0]  id_word;
  logic id_valid, err, done;

  always #5 clk = ~clk;

  jtag_enum_master #(.DIV_W(DIV_W), .IR_MAX(IR_MAX), .MAX_DEV(MAX_DEV), .ID_W(ID_W)) u_jtag_enum_master (
    .clk(clk), .rst(rst), .start(start), .div(div), .tdo(tdo), .tck(tck), .tms(tms),
    .tdi(tdi), .dev_count(dev_count), .id_word(id_word), .id_valid(id_valid),
    .err(err), .done(done));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural chain ----------------
  typedef enum logic [3:0] {T_TLR, T_RTI, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PAUDR, T_EX2DR,
                            T_UPDR, T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PAUIR, T_EX2IR, T_UPIR} tap_t;
  tap_t tap = T_SHIR;

  function automatic tap_t tap_next(tap_t s, logic m);
    case (s)
      T_TLR:   return m ? T_TLR   : T_RTI;
      T_RTI:   return m ? T_SELDR : T_RTI;
      T_SELDR: return m ? T_SELIR : T_CAPDR;
      T_CAPDR: return m ? T_EX1DR : T_SHDR;
      T_SHDR:  return m ? T_EX1DR : T_SHDR;
      T_EX1DR: return m ? T_UPDR  : T_PAUDR;
      T_PAUDR: return m ? T_EX2DR : T_PAUDR;
      T_EX2DR: return m ? T_UPDR  : T_SHDR;
      T_UPDR:  return m ? T_SELDR : T_RTI;
      T_SELIR: return m ? T_TLR   : T_CAPIR;
      T_CAPIR: return m ? T_EX1IR : T_SHIR;
      T_SHIR:  return m ? T_EX1IR : T_SHIR;
      T_EX1IR: return m ? T_UPIR  : T_PAUIR;
      T_PAUIR: return m ? T_EX2IR : T_PAUIR;
      T_EX2IR: return m ? T_UPIR  : T_SHIR;
      default: return m ? T_SELDR : T_RTI;
    endcase
  endfunction

  function automatic logic [31:0] id_of(int i);
    case (i)
      0: return 32'h10A1_5031;
      1: return 32'h2B0C_7043;
      2: return 32'h3C9D_0E15;
      default: return 32'h4F2E_6A87;
    endcase
  endfunction

  function automatic logic [7:0] mask_of(int i);
    return (8'd1 << (4 + i)) - 8'd1;
  endfunction

  logic [31:0] idsr [4];
  logic [7:0]  irsr [4];
  logic        byp  [4];
  logic        selid[4];
  logic        tq   [4] = '{1'b0, 1'b0, 1'b0, 1'b0};
  int  ndev = 0;
  bit  stuck = 0;
  bit  ir_all_ones = 0;

  function automatic logic din_of(int i);
    return (i == 0) ? tdi : tq[i-1];
  endfunction

  always_comb tdo = stuck ? 1'b0 : ((ndev == 0) ? tdi : tq[ndev-1]);

  always @(posedge tck) begin : chain_rise
    bit all;
    for (int i = 0; i < 4; i++) begin
      case (tap)
        T_TLR:   selid[i] <= 1'b1;
        T_CAPDR: begin byp[i] <= 1'b0; idsr[i] <= id_of(i); end
        T_SHDR:  if (selid[i]) idsr[i] <= {din_of(i), idsr[i][31:1]};
                 else byp[i] <= din_of(i);
        T_CAPIR: irsr[i] <= 8'h01;
        T_SHIR:  irsr[i] <= (irsr[i] >> 1) | (8'(din_of(i)) << (3 + i));
        T_UPIR:  selid[i] <= ((irsr[i] & mask_of(i)) != mask_of(i));
        default: ;
      endcase
    end
    if (tap == T_UPIR) begin
      all = 1;
      for (int i = 0; i < ndev; i++)
        if ((irsr[i] & mask_of(i)) != mask_of(i)) all = 0;
      ir_all_ones = all;
    end
    tap <= tap_next(tap, tms);
  end

  always @(negedge tck) begin
    for (int i = 0; i < 4; i++) begin
      if (tap == T_SHIR)      tq[i] <= irsr[i][0];
      else if (tap == T_SHDR) tq[i] <= selid[i] ? idsr[i][0] : byp[i];
    end
  end

  // ---------------- monitors ----------------
  logic [31:0] expq[$];
  int  rises = 0;
  bit  r1_bad = 0, per_bad = 0, r3_bad = 0, armed = 0, have_rise = 0;
  int  exp_per = 4, clk_cnt = 0;
  logic tck_p = 0, tms_p = 0, tdi_p = 0;

  always @(posedge tck) begin
    rises++;
    if (rises <= 5 && !tms) r1_bad = 1;
    if (rises == 6 && tms)  r1_bad = 1;
  end

  always @(negedge clk) begin
    if (armed && ((tms !== tms_p) || (tdi !== tdi_p)) && !(tck_p && !tck)) r3_bad = 1;
    clk_cnt++;
    if (tck && !tck_p) begin
      armed = 1;
      if (have_rise && clk_cnt != exp_per) per_bad = 1;
      have_rise = 1;
      clk_cnt = 0;
    end
    tms_p = tms; tdi_p = tdi; tck_p = tck;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && id_valid) begin
      if (expq.size() == 0) chk(1'b0, "R7", "unexpected id word", id_word, 32'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(id_word == e, "R7", "id word", id_word, e);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic run_scan(input int n, input bit stk, input logic [DIV_W-1:0] dv, input bit poke);
    string creq;
    ndev = n; stuck = stk; div = dv;
    exp_per = 2 * (int'(dv) + 1);
    rises = 0; r1_bad = 0; per_bad = 0; r3_bad = 0; armed = 0; have_rise = 0;
    ir_all_ones = 0;
    if (!stk) for (int i = n - 1; i >= 0; i--) expq.push_back(id_of(i));
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (200) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (!done) @(negedge clk);
    creq = poke ? "R10" : (stk ? "R6" : (n == 0 ? "R9" : "R5"));
    chk(dev_count == DEV_W'(stk ? 0 : n), creq, "device count", 32'(dev_count), 32'(stk ? 0 : n));
    chk(err == stk, stk ? "R6" : "R9", "error flag", 32'(err), 32'(stk));
    chk(expq.size() == 0, stk ? "R6" : "R7", "words left", 32'(expq.size()), 32'h0);
    chk(tap == T_RTI, "R8", "chain parked state", 32'(tap), 32'(T_RTI));
    chk(tck == 1'b0, "R8", "tck at done", 32'(tck), 32'h0);
    chk(!r1_bad, "R1", "tms reset prefix", 32'(r1_bad), 32'h0);
    chk(!per_bad, "R2", "tck period", 32'(per_bad), 32'h0);
    chk(!r3_bad, "R3", "tms/tdi away from falling tck", 32'(r3_bad), 32'h0);
    chk(ir_all_ones, "R4", "all-ones instruction in every device", 32'(ir_all_ones), 32'h1);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done width", 32'(done), 32'h0);
    expq.delete();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tck == 1'b0, "R2", "tck after reset", 32'(tck), 32'h0);
    chk(done == 1'b0 && id_valid == 1'b0, "R8", "strobes after reset", 32'({done, id_valid}), 32'h0);
    chk(err == 1'b0 && dev_count == '0, "R6", "results after reset", 32'({err, dev_count}), 32'h0);
    run_scan(3, 1'b0, 4'd1, 1'b0);
    run_scan(1, 1'b0, 4'd0, 1'b0);
    run_scan(4, 1'b0, 4'd2, 1'b1);
    run_scan(0, 1'b0, 4'd1, 1'b0);
    run_scan(2, 1'b1, 4'd0, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R8 watchdog: actual=no-done expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule